// File: doc/BRIEF.md
# Rotating Sense-Element Selector and Auto-Zero Phase Sequencer

This block produces the digital control for a current sensor that averages out element mismatch. The analog side has an array of matched sense elements, of which exactly one conducts at a time. It also has two identical amplifier stages. In each switching cycle one stage samples its own offset with unity feedback, while the other stage senses with its stored offset in series. The block moves the active element by one position in every switching cycle, so the averaged reading covers the whole array once per `SENSE_COUNT` cycles. It also swaps the two stage roles each cycle and raises a hold phase whenever the dead-time indicator is high, which freezes the sensed value while neither power switch conducts.

A switching cycle begins when the sampled high-side gate command goes from low to high. A phase state machine with four named states drives the phases: `PH_WAIT` (after reset, before the first cycle), `PH_SENSE` (high-side conduction), `PH_HOLD` (dead time) and `PH_LOW` (low-side conduction). The transitions are:
- *start*: any state goes to `PH_SENSE` on a rising edge, and this transition has priority.
- *enter dead time*: `PH_SENSE` or `PH_LOW` goes to `PH_HOLD` while the dead-time indicator is high.
- *resume high*: `PH_HOLD` goes to `PH_SENSE` when dead time ends with the command still high.
- *resume low*: `PH_HOLD` goes to `PH_LOW` when dead time ends with the command low.
- *fall*: `PH_SENSE` goes to `PH_LOW` when the command falls without dead time.

`PH_WAIT` leaves only through *start*. All outputs follow from registers one clock after the inputs are sampled.

Top module: `senserot_top`

## Requirements
- R1: While reset is applied, and after reset until the first rising edge of the high-side command, `elem_sel` is 1 (element 0) and `elem_idx` is 0. All of `az_a`, `az_b`, `sns_a`, `sns_b` and `hold` are low, and the dead-time input has no effect on them.
- R2: Exactly one bit of `elem_sel` is high in every cycle.
- R3: The first rising edge after reset keeps element 0. Each later rising edge advances `elem_idx` by one, and after `SENSE_COUNT-1` it wraps to 0. The edge is the command sampled high at a clock edge after being sampled low at the previous clock edge.
- R4: The bit of `elem_sel` that is high is bit number `elem_idx`.
- R5: Cycles are counted from 1 at the first rising edge after reset. In odd cycles stage A auto-zeroes (`az_a`) and stage B senses (`sns_b`). In even cycles stage B auto-zeroes (`az_b`) and stage A senses (`sns_a`).
- R6: One clock after a rising edge is sampled, the sensing stage's sense output is high. It stays high while the command stays high and dead time is low.
- R7: From one clock after dead time is sampled high (outside `PH_WAIT`), `hold` is high and both sense outputs are low. The auto-zeroing stage keeps `az` high.
- R8: No stage has its auto-zero and sense outputs high together. The two sense outputs are never high together, and neither are the two auto-zero outputs.
- R9: During low-side conduction (command low, no dead time, after a cycle has started), both sense outputs and `hold` are low, and the auto-zeroing stage keeps `az` high.
- R10: `elem_idx` and `elem_sel` do not change at any clock edge without a sampled rising edge, whatever the command level or dead-time input.
- R11: A rising edge sampled together with dead time high still starts the cycle: the state goes to `PH_SENSE` and `hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the switching rate |
| rst | input | 1 | Synchronous reset, active high |
| hs_cmd | input | 1 | High-side gate command; a rising edge starts a switching cycle |
| dead_time | input | 1 | High while neither power switch conducts |
| elem_sel | output | SENSE_COUNT | One-hot enable of the active sense element |
| elem_idx | output | $clog2(SENSE_COUNT) (5 by default) | Binary number of the active element |
| az_a | output | 1 | Stage A in offset sampling (unity feedback) |
| az_b | output | 1 | Stage B in offset sampling |
| sns_a | output | 1 | Stage A sensing with stored offset in series |
| sns_b | output | 1 | Stage B sensing |
| hold | output | 1 | Freezes the sensed value during dead time |

## Verification
The bench sweeps seventy switching cycles, which passes the 32-element ring twice. The lengths of the high and low intervals differ from cycle to cycle, which exposes any advance tied to interval length rather than to the rising edge. Some cycles have no dead time, so a hold that is missing or stuck shows up. A dead-time pulse placed inside the high interval shows whether `PH_HOLD` correctly returns to `PH_SENSE`. A rising edge that coincides with dead time shows whether *start* has priority. A second reset in the middle of the run, followed by fresh cycles, shows whether the element and role parity both restart, separately from the rotation logic.

// File: rtl/senserot_pkg.sv
package senserot_pkg;

    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_SENSE = 2'd1,
        PH_HOLD  = 2'd2,
        PH_LOW   = 2'd3
    } phase_t;

    typedef struct packed {
        logic az_a;
        logic az_b;
        logic sns_a;
        logic sns_b;
        logic hold;
    } ctl_t;

endpackage

// File: rtl/senserot_edge.sv
module senserot_edge (
    input  logic clk,
    input  logic rst,
    input  logic hs_cmd,
    output logic rise
);

    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
        end else begin
            hs_q <= hs_cmd;
        end
    end

    assign rise = hs_cmd & ~hs_q;

endmodule

// File: rtl/senserot_ring.sv
module senserot_ring #(
    parameter int SENSE_COUNT = 32,
    localparam int IDX_W = $clog2(SENSE_COUNT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rise,
    output logic [SENSE_COUNT-1:0] sel,
    output logic [IDX_W-1:0]       idx,
    output logic                   odd
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(SENSE_COUNT - 1);

    logic                   started;
    logic                   step;
    logic [SENSE_COUNT-1:0] sel_nxt;

    assign step = rise & started;

    generate
        for (genvar g = 0; g < SENSE_COUNT; g++) begin : g_ring
            if (g == 0) begin : g_head
                assign sel_nxt[g] = sel[SENSE_COUNT-1];
            end else begin : g_body
                assign sel_nxt[g] = sel[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
        end else if (rise) begin
            started <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SENSE_COUNT'(1);
        end else if (step) begin
            sel <= sel_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            odd <= 1'b1;
        end else if (step) begin
            odd <= ~odd;
        end
    end

endmodule

// File: rtl/senserot_fsm.sv
module senserot_fsm
    import senserot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rise,
    input  logic   hs_cmd,
    input  logic   dead_time,
    input  logic   odd,
    output phase_t phase,
    output ctl_t   ctl
);

    phase_t phase_nxt;

    always_comb begin
        phase_nxt = phase;
        if (rise) begin
            phase_nxt = PH_SENSE;
        end else begin
            unique case (phase)
                PH_WAIT:  phase_nxt = PH_WAIT;
                PH_SENSE: begin
                    if (dead_time)     phase_nxt = PH_HOLD;
                    else if (!hs_cmd)  phase_nxt = PH_LOW;
                end
                PH_HOLD: begin
                    if (!dead_time)    phase_nxt = hs_cmd ? PH_SENSE : PH_LOW;
                end
                PH_LOW: begin
                    if (dead_time)     phase_nxt = PH_HOLD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WAIT;
        end else begin
            phase <= phase_nxt;
        end
    end

    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_WAIT: ctl = '0;
            PH_SENSE: begin
                ctl.az_a  = odd;
                ctl.az_b  = ~odd;
                ctl.sns_a = ~odd;
                ctl.sns_b = odd;
            end
            PH_HOLD: begin
                ctl.az_a = odd;
                ctl.az_b = ~odd;
                ctl.hold = 1'b1;
            end
            PH_LOW: begin
                ctl.az_a = odd;
                ctl.az_b = ~odd;
            end
        endcase
    end

endmodule

// File: rtl/senserot_top.sv
module senserot_top #(
    parameter int SENSE_COUNT = 32,
    localparam int IDX_W = $clog2(SENSE_COUNT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hs_cmd,
    input  logic                   dead_time,
    output logic [SENSE_COUNT-1:0] elem_sel,
    output logic [IDX_W-1:0]       elem_idx,
    output logic                   az_a,
    output logic                   az_b,
    output logic                   sns_a,
    output logic                   sns_b,
    output logic                   hold
);

    import senserot_pkg::*;

    logic   rise_w;
    logic   odd_w;
    phase_t phase_w;
    ctl_t   ctl_w;

    senserot_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .hs_cmd (hs_cmd),
        .rise   (rise_w)
    );

    senserot_ring #(.SENSE_COUNT(SENSE_COUNT)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .rise (rise_w),
        .sel  (elem_sel),
        .idx  (elem_idx),
        .odd  (odd_w)
    );

    senserot_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise_w),
        .hs_cmd    (hs_cmd),
        .dead_time (dead_time),
        .odd       (odd_w),
        .phase     (phase_w),
        .ctl       (ctl_w)
    );

    assign az_a  = ctl_w.az_a;
    assign az_b  = ctl_w.az_b;
    assign sns_a = ctl_w.sns_a;
    assign sns_b = ctl_w.sns_b;
    assign hold  = ctl_w.hold;

endmodule

// File: rtl/senserot_chk.sv
module senserot_chk #(
    parameter int SENSE_COUNT = 32,
    localparam int IDX_W = $clog2(SENSE_COUNT)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rise,
    input logic                   dead_time,
    input logic [1:0]             phase,
    input logic [SENSE_COUNT-1:0] elem_sel,
    input logic [IDX_W-1:0]       elem_idx,
    input logic                   az_a,
    input logic                   az_b,
    input logic                   sns_a,
    input logic                   sns_b,
    input logic                   hold
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(elem_sel) == 1);

    p_sel_idx_r4: assert property (@(posedge clk) disable iff (rst)
        elem_sel[elem_idx] == 1'b1);

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (rise && elem_idx == IDX_W'(SENSE_COUNT - 1)) |=> elem_idx == '0);

    p_idx_stable_r10: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ($stable(elem_idx) && $stable(elem_sel)));

    p_stage_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(az_a && sns_a) && !(az_b && sns_b) && !(sns_a && sns_b) && !(az_a && az_b));

    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        hold |-> (!sns_a && !sns_b));

    p_dead_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (dead_time && !rise && phase != 2'd0) |=> hold);

    p_rise_sense_r11: assert property (@(posedge clk) disable iff (rst)
        rise |=> ((sns_a || sns_b) && !hold));

endmodule

bind senserot_top senserot_chk #(.SENSE_COUNT(SENSE_COUNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise_w),
    .dead_time (dead_time),
    .phase     (phase_w),
    .elem_sel  (elem_sel),
    .elem_idx  (elem_idx),
    .az_a      (az_a),
    .az_b      (az_b),
    .sns_a     (sns_a),
    .sns_b     (sns_b),
    .hold      (hold)
);

// File: tb/test_senserot_top.sv
module test_senserot_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 32;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hs_cmd = 1'b0;
    logic          dead_time = 1'b0;
    logic [N-1:0]  elem_sel;
    logic [IW-1:0] elem_idx;
    logic          az_a, az_b, sns_a, sns_b, hold;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int mode   = 0;
    logic prev_hs = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    senserot_top #(.SENSE_COUNT(N)) i_senserot_top (
        .clk(clk), .rst(rst), .hs_cmd(hs_cmd), .dead_time(dead_time),
        .elem_sel(elem_sel), .elem_idx(elem_idx),
        .az_a(az_a), .az_b(az_b), .sns_a(sns_a), .sns_b(sns_b), .hold(hold)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        int          ei;
        bit          od;
        logic [4:0]  ph;
        logic [4:0]  eph;
        ei = (cyc == 0) ? 0 : (cyc - 1) % N;
        od = (cyc == 0) || (cyc % 2 == 1);
        ph = {az_a, az_b, sns_a, sns_b, hold};
        case (mode)
            1:       eph = {od, !od, !od, od, 1'b0};
            2:       eph = {od, !od, 1'b0, 1'b0, 1'b1};
            3:       eph = {od, !od, 1'b0, 1'b0, 1'b0};
            default: eph = 5'b0;
        endcase
        chk(elem_idx == IW'(ei), {ctx, " R3 R10 index"}, 64'(elem_idx), 64'(ei));
        chk(elem_sel == (N'(1) << ei), {ctx, " R2 R4 select"}, 64'(elem_sel), 64'(N'(1) << ei));
        case (mode)
            0: chk(ph == eph, {ctx, " R1 idle phases"}, 64'(ph), 64'(eph));
            1: chk(ph == eph, {ctx, " R5 R6 sense phases"}, 64'(ph), 64'(eph));
            2: chk(ph == eph, {ctx, " R7 hold phases"}, 64'(ph), 64'(eph));
            default: chk(ph == eph, {ctx, " R9 low phases"}, 64'(ph), 64'(eph));
        endcase
        chk(!(az_a && sns_a) && !(az_b && sns_b) && !(sns_a && sns_b),
            {ctx, " R8 exclusion"}, 64'(ph), 64'(eph));
    endtask

    task automatic tick(input logic h, input logic d);
        string ctx;
        @(negedge clk);
        hs_cmd    = h;
        dead_time = d;
        @(posedge clk);
        #1;
        ctx = "step";
        if (h && !prev_hs) begin
            cyc++;
            mode = 1;
            if (d) ctx = "R11 rise in dead time";
        end else if (mode == 0) begin
            mode = 0;
        end else if (d) begin
            mode = 2;
        end else if (mode == 2) begin
            mode = h ? 1 : 3;
        end else if (mode == 1 && !h) begin
            mode = 3;
        end
        prev_hs = h;
        check_all(ctx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        hs_cmd = 1'b0;
        dead_time = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        cyc = 0;
        mode = 0;
        prev_hs = 1'b0;
        check_all("R1 in reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        for (int k = 0; k < 70; k++) begin
            int  hl;
            int  ll;
            bit  dt;
            hl = 1 + k % 3;
            ll = 1 + k % 4;
            dt = (k % 5 != 4);
            tick(1'b1, (k % 7 == 3) ? 1'b1 : 1'b0);
            for (int j = 1; j < hl; j++) tick(1'b1, 1'b0);
            if (k % 6 == 2) begin
                tick(1'b1, 1'b1);
                tick(1'b1, 1'b0);
            end
            if (dt) tick(1'b0, 1'b1);
            for (int j = 0; j < ll; j++) tick(1'b0, 1'b0);
            if (dt) tick(1'b0, 1'b1);
        end
        tick(1'b1, 1'b0);
        do_reset();
        tick(1'b0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            tick(1'b1, 1'b0);
            tick(1'b1, 1'b0);
            tick(1'b0, 1'b1);
            tick(1'b0, 1'b0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule